// File: doc/BRIEF.md
# Chained Carry-Save Floating-Point Multiplier

This block multiplies two 24-bit floating-point operands. Each operand holds a 16-bit two's-complement fraction and an 8-bit biased exponent. The mantissa product is never passed through a carry-propagate adder on the way to the accumulator. Instead the block emits two vectors, a sum and a carry, whose modular sum is the product. It also emits the product exponent. The product can be shifted right by an alignment amount before it leaves, so that a downstream carry-save accumulator can add it directly. The output is 40 bits wide, which gives eight guard positions, so the shift loses no bits.

A product that is only one factor of a longer chain of multiplications takes a second path. It is resolved to plain binary, truncated back to the 24-bit format, and parked in a one-entry intermediate buffer. A later execution word can name that buffer as its second operand in place of the data word. Reading the buffer empties it. Writing the buffer while it still holds an unread value is refused and reported. The pipeline accepts one execution word per clock.

Top module: `csm_unit`

## Requirements
- R1: An operand word carries the mantissa (Q1.15 two's complement) in bits 23:8 and the exponent (excess-64) in bits 7:0. The product exponent on `sum_exp_o` is ea + eb - 64 + k, taken modulo 256, where k is the applied alignment.
- R2: For a non-chained word, (`sum_s_o` + `sum_c_o`) mod 2^40 equals ma*mb*2^(8-k). Here k is `align_i`, and any value above 8 acts as 8.
- R3: A non-chained word sampled at clock edge n makes `sum_vld_o` high for exactly the one cycle that follows edge n+11.
- R4: A chained word (`chain_i`=1) never raises `sum_vld_o` and ignores `align_i`. After edge n+13 the buffer holds {bits 30:15 of the 32-bit product ma*mb, ea+eb-64}, and `buf_vld_o` is high.
- R5: With `use_buf_i`=1 the buffered word replaces `opb_i` as the second operand, and the read empties the buffer. A write landing on the same edge as the read fills the buffer with the new word, and the read still returns the old word.
- R6: A write while the buffer is full and not being read keeps the stored word and drops the new one. It also raises `wr_clash_o` for one cycle.
- R7: A read from an empty buffer supplies the all-zero word as the operand and raises `rd_empty_o` for one cycle.
- R8: While `rst_ni` is low, every output is zero.
- R9: Words issued on consecutive cycles each produce their own result, in issue order, one per cycle.
- R10: Whenever `sum_vld_o` is low, `sum_s_o`, `sum_c_o` and `sum_exp_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An execution word is present this cycle |
| chain_i | input | 1 | 1: resolve the product into the buffer; 0: send it to the accumulator |
| use_buf_i | input | 1 | Take the second operand from the buffer |
| align_i | input | 4 | Right-shift amount applied to the carry-save product |
| opa_i | input | 24 | First operand word |
| opb_i | input | 24 | Second operand word (data word) |
| sum_vld_o | output | 1 | Carry-save product valid for the accumulator |
| sum_s_o | output | 40 | Sum vector of the product |
| sum_c_o | output | 40 | Carry vector of the product |
| sum_exp_o | output | 8 | Product exponent |
| buf_vld_o | output | 1 | The buffer holds an unread intermediate |
| buf_word_o | output | 24 | Buffer contents |
| wr_clash_o | output | 1 | A write was refused because the buffer was full |
| rd_empty_o | output | 1 | A buffer read found the buffer empty |

## Verification
A carry-save reduction error does not show up in either vector taken alone. It shows only in their modular sum, 12 cycles after issue. For that reason each result is checked by adding the two vectors and comparing the total against the arithmetic product. An off-by-one delay stage moves `sum_vld_o`, or the rise of `buf_vld_o`, to a different cycle. The checks sample the exact cycle, so such a shift is caught at once. A wrong buffer valid flag appears within one cycle, as a wrong clash or empty pulse, or later as a wrong operand in the product that consumes the buffer.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int unsigned CSM_MANT_W    = 16;
  localparam int unsigned CSM_EXP_W     = 8;
  localparam int unsigned CSM_EXP_BIAS  = 64;
  localparam int unsigned CSM_ALIGN_MAX = 8;

  typedef enum logic {
    PATH_SUM   = 1'b0,
    PATH_CHAIN = 1'b1
  } csm_path_e;
endpackage

// File: rtl/csm_delay.sv
module csm_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_pipe
    logic [WIDTH-1:0] st [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) st[k] <= '0;
      end else begin
        st[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) st[k] <= st[k-1];
      end
    end
    assign q_o = st[DEPTH-1];
  end
endmodule

// File: rtl/csm_csa_tree.sv
module csm_csa_tree #(
  parameter int unsigned MANT_W    = 16,
  parameter int unsigned ALIGN_MAX = 8,
  parameter int unsigned W         = 2*MANT_W + ALIGN_MAX,
  parameter int unsigned SH_W      = $clog2(ALIGN_MAX + 1)
) (
  input  logic [MANT_W-1:0] a_m_i,
  input  logic [MANT_W-1:0] b_m_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [W-1:0]      s_o,
  output logic [W-1:0]      c_o
);
  localparam int unsigned NR = MANT_W + 1;

  logic [W-1:0]    ax;
  logic [SH_W-1:0] lift;
  logic [W-1:0]    row [NR];

  assign ax   = W'($signed(a_m_i));
  assign lift = SH_W'(ALIGN_MAX) - sh_i;

  // rows 0..MANT_W-2 positive weight, top bit negative: ~x + 1
  for (genvar i = 0; i < MANT_W - 1; i++) begin : g_row
    assign row[i] = b_m_i[i] ? (ax << (i + lift)) : '0;
  end
  assign row[MANT_W-1] = b_m_i[MANT_W-1] ? ~(ax << (MANT_W - 1 + lift)) : '0;
  assign row[MANT_W]   = {{(W-1){1'b0}}, b_m_i[MANT_W-1]};

  always_comb begin
    logic [W-1:0] s_acc, c_acc, r;
    s_acc = row[0];
    c_acc = row[1];
    for (int j = 2; j < NR; j++) begin
      r     = row[j];
      {s_acc, c_acc} = {s_acc ^ c_acc ^ r,
                        ((s_acc & c_acc) | (s_acc & r) | (c_acc & r)) << 1};
    end
    s_o = s_acc;
    c_o = c_acc;
  end
endmodule

// File: rtl/csm_ibuf.sv
module csm_ibuf #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              rd_en_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              wr_clash_o,
  output logic              rd_empty_o
);
  logic              vld_q, clash_q, empty_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      word_q  <= '0;
      clash_q <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      clash_q <= wr_en_i & vld_q & ~rd_en_i;
      empty_q <= rd_en_i & ~vld_q;
      if (wr_en_i && (!vld_q || rd_en_i)) begin
        vld_q  <= 1'b1;
        word_q <= wr_word_i;
      end else if (rd_en_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign vld_o      = vld_q;
  assign word_o     = word_q;
  assign rd_word_o  = vld_q ? word_q : '0;
  assign wr_clash_o = clash_q;
  assign rd_empty_o = empty_q;

  p_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !vld_q |=> vld_o && (word_o == $past(wr_word_i)));
  p_rd_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i |=> !vld_o);
  p_clash_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && vld_q && !rd_en_i |=> wr_clash_o && $stable(word_o) && vld_o);
  p_empty_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !vld_q |=> rd_empty_o);
endmodule

// File: rtl/csm_unit.sv
module csm_unit
  import csm_pkg::*;
#(
  parameter int unsigned MANT_W    = CSM_MANT_W,
  parameter int unsigned EXP_W     = CSM_EXP_W,
  parameter int unsigned EXP_BIAS  = CSM_EXP_BIAS,
  parameter int unsigned ALIGN_MAX = CSM_ALIGN_MAX,
  parameter int unsigned LOAD_LAT  = 2,
  parameter int unsigned EXEC_LAT  = 8,
  parameter int unsigned READY_LAT = 2,
  parameter int unsigned FB_LAT    = 2,
  parameter int unsigned WORD_W    = MANT_W + EXP_W,
  parameter int unsigned W         = 2*MANT_W + ALIGN_MAX,
  parameter int unsigned SH_W      = $clog2(ALIGN_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              chain_i,
  input  logic              use_buf_i,
  input  logic [SH_W-1:0]   align_i,
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  output logic              sum_vld_o,
  output logic [W-1:0]      sum_s_o,
  output logic [W-1:0]      sum_c_o,
  output logic [EXP_W-1:0]  sum_exp_o,
  output logic              buf_vld_o,
  output logic [WORD_W-1:0] buf_word_o,
  output logic              wr_clash_o,
  output logic              rd_empty_o
);
  localparam int unsigned MID_LAT = EXEC_LAT + READY_LAT;
  localparam int unsigned RES_TOP = ALIGN_MAX + 2*MANT_W - 2;

  typedef struct packed {
    logic              vld;
    csm_path_e         path;
    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] ma;
    logic [MANT_W-1:0] mb;
    logic [EXP_W-1:0]  ex;
  } ld_t;

  typedef struct packed {
    logic             vld;
    csm_path_e        path;
    logic [W-1:0]     s;
    logic [W-1:0]     c;
    logic [EXP_W-1:0] ex;
  } px_t;

  typedef struct packed {
    logic              vld;
    logic [WORD_W-1:0] word;
  } fb_t;

  ld_t ld_in, ld_q;
  px_t px_in, px_q;
  fb_t fb_in, fb_q;

  logic [WORD_W-1:0] buf_rd_word, bsel;
  logic [SH_W-1:0]   sh_lim;
  logic [W-1:0]      csa_s, csa_c, full;

  // operand select and exponent at load
  assign bsel   = use_buf_i ? buf_rd_word : opb_i;
  assign sh_lim = (align_i > SH_W'(ALIGN_MAX)) ? SH_W'(ALIGN_MAX) : align_i;

  always_comb begin
    ld_in = '0;
    if (issue_i) begin
      ld_in.vld  = 1'b1;
      ld_in.path = chain_i ? PATH_CHAIN : PATH_SUM;
      ld_in.sh   = chain_i ? '0 : sh_lim;
      ld_in.ma   = opa_i[WORD_W-1 -: MANT_W];
      ld_in.mb   = bsel[WORD_W-1 -: MANT_W];
      ld_in.ex   = opa_i[EXP_W-1:0] + bsel[EXP_W-1:0] - EXP_W'(EXP_BIAS)
                 + EXP_W'(ld_in.sh);
    end
  end

  csm_delay #(.WIDTH($bits(ld_t)), .DEPTH(LOAD_LAT)) u_ld (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ld_in), .q_o(ld_q)
  );

  csm_csa_tree #(.MANT_W(MANT_W), .ALIGN_MAX(ALIGN_MAX), .W(W), .SH_W(SH_W)) u_csa (
    .a_m_i(ld_q.ma), .b_m_i(ld_q.mb), .sh_i(ld_q.sh), .s_o(csa_s), .c_o(csa_c)
  );

  always_comb begin
    px_in      = '0;
    px_in.vld  = ld_q.vld;
    px_in.path = ld_q.path;
    px_in.s    = csa_s;
    px_in.c    = csa_c;
    px_in.ex   = ld_q.ex;
  end

  csm_delay #(.WIDTH($bits(px_t)), .DEPTH(MID_LAT)) u_mid (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(px_in), .q_o(px_q)
  );

  // accumulator path
  assign sum_vld_o = px_q.vld & (px_q.path == PATH_SUM);
  assign sum_s_o   = sum_vld_o ? px_q.s  : '0;
  assign sum_c_o   = sum_vld_o ? px_q.c  : '0;
  assign sum_exp_o = sum_vld_o ? px_q.ex : '0;

  // chain path: propagate carries, truncate to operand format
  assign full = px_q.s + px_q.c;

  always_comb begin
    fb_in = '0;
    if (px_q.vld && px_q.path == PATH_CHAIN) begin
      fb_in.vld  = 1'b1;
      fb_in.word = {full[RES_TOP -: MANT_W], px_q.ex};
    end
  end

  csm_delay #(.WIDTH($bits(fb_t)), .DEPTH(FB_LAT - 1)) u_fb (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fb_in), .q_o(fb_q)
  );

  csm_ibuf #(.WORD_W(WORD_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(fb_q.vld), .wr_word_i(fb_q.word),
    .rd_en_i(issue_i & use_buf_i),
    .vld_o(buf_vld_o), .word_o(buf_word_o), .rd_word_o(buf_rd_word),
    .wr_clash_o(wr_clash_o), .rd_empty_o(rd_empty_o)
  );

  p_csa_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_q.vld |-> (csa_s + csa_c) ==
      ((W'($signed(ld_q.ma)) * W'($signed(ld_q.mb))) << (ALIGN_MAX - ld_q.sh)));
  p_chain_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_q.vld && ld_q.path == PATH_CHAIN |-> ld_q.sh == '0);
endmodule

// File: tb/sim_csm_unit.sv
module sim_csm_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0, chain_i = 1'b0, use_buf_i = 1'b0;
  logic [3:0]  align_i = '0;
  logic [23:0] opa_i = '0, opb_i = '0;
  logic        sum_vld_o, buf_vld_o, wr_clash_o, rd_empty_o;
  logic [39:0] sum_s_o, sum_c_o;
  logic [7:0]  sum_exp_o;
  logic [23:0] buf_word_o;

  int total = 0, bad = 0, t = 0;
  bit done = 1'b0;
  bit          ev_v [32];
  logic [39:0] ev_p [32];
  logic [7:0]  ev_e [32];

  always #4 clk_i = ~clk_i;

  csm_unit u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0d act=%h exp=%h", req, t, act, expv);
    end
  endtask

  function automatic logic [15:0] mval(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h7FFF;
      3: return 16'h8000; 4: return 16'hFFFF; 5: return 16'h4000;
      6: return 16'hC000; 7: return 16'h1234; default: return 16'hA5A5;
    endcase
  endfunction

  function automatic logic [39:0] prod40(input logic [15:0] ma, mb, input int k);
    logic signed [31:0] p;
    p = $signed(ma) * $signed(mb);
    return {{8{p[31]}}, p} << (8 - k);
  endfunction

  function automatic logic [23:0] resolved(input logic [23:0] a, b);
    logic signed [31:0] p;
    p = $signed(a[23:8]) * $signed(b[23:8]);
    return {p[30:15], 8'(a[7:0] + b[7:0] - 8'd64)};
  endfunction

  task automatic sched(input int at, input logic [39:0] p, input logic [7:0] e);
    ev_v[at % 32] = 1'b1;
    ev_p[at % 32] = p;
    ev_e[at % 32] = e;
  endtask

  task automatic tick(input bit iss, ch, ub, input logic [3:0] al, input logic [23:0] a, b);
    logic [39:0] sc;
    sc = sum_s_o + sum_c_o;
    if (ev_v[t % 32]) begin
      chk(sum_vld_o == 1'b1, "R3/R9 valid", 64'(sum_vld_o), 64'd1);
      chk(sc == ev_p[t % 32], "R2 product", 64'(sc), 64'(ev_p[t % 32]));
      chk(sum_exp_o == ev_e[t % 32], "R1 exponent", 64'(sum_exp_o), 64'(ev_e[t % 32]));
      ev_v[t % 32] = 1'b0;
    end else begin
      chk(!sum_vld_o && sum_s_o == '0 && sum_c_o == '0 && sum_exp_o == '0,
          "R10 quiet", {23'd0, sum_vld_o, sum_s_o}, 64'd0);
    end
    issue_i = iss; chain_i = ch; use_buf_i = ub; align_i = al; opa_i = a; opb_i = b;
    @(negedge clk_i);
    t++;
  endtask

  task automatic idle_until(input int target);
    while (t < target) tick(0, 0, 0, 4'd0, 24'd0, 24'd0);
  endtask

  initial begin
    int t0, t1;
    logic [23:0] w1, w2, w3, a, b;
    for (int i = 0; i < 32; i++) ev_v[i] = 1'b0;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk(!sum_vld_o && sum_s_o == '0 && sum_c_o == '0 && sum_exp_o == '0,
        "R8 sum outputs", {23'd0, sum_vld_o, sum_s_o}, 64'd0);
    chk(!buf_vld_o && buf_word_o == '0 && !wr_clash_o && !rd_empty_o,
        "R8 buffer outputs", {buf_vld_o, wr_clash_o, rd_empty_o, buf_word_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t = 0;

    // R2/R9: streamed sweep, one word per cycle, alignment incl. clamp above 8
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        int k, kc;
        k  = (i + j) % 10;
        kc = (k > 8) ? 8 : k;
        a  = {mval(i), 8'(i * 7 + 60)};
        b  = {mval(j), 8'(j * 5 + 40)};
        sched(t + 12, prod40(a[23:8], b[23:8], kc), 8'(a[7:0] + b[7:0] - 8'd64 + 8'(kc)));
        tick(1, 0, 0, 4'(k), a, b);
      end
    end
    idle_until(t + 14);

    // R4: chained product lands in the buffer, never on the sum port
    a = {16'h4000, 8'd70}; b = {16'h6000, 8'd66};
    w1 = resolved(a, b);
    t0 = t;
    tick(1, 1, 0, 4'd5, a, b);
    idle_until(t0 + 13);
    chk(!buf_vld_o, "R4 buffer not yet written", 64'(buf_vld_o), 64'd0);
    tick(0, 0, 0, 4'd0, 24'd0, 24'd0);
    chk(buf_vld_o && buf_word_o == w1, "R4 buffer word", {buf_vld_o, buf_word_o}, {1'b1, w1});

    // R6: write while full is refused
    a = {16'h2000, 8'd64}; b = {16'h2000, 8'd64};
    t0 = t;
    tick(1, 1, 0, 4'd0, a, b);
    idle_until(t0 + 14);
    chk(wr_clash_o == 1'b1, "R6 clash flag", 64'(wr_clash_o), 64'd1);
    chk(buf_vld_o && buf_word_o == w1, "R6 word kept", {buf_vld_o, buf_word_o}, {1'b1, w1});
    tick(0, 0, 0, 4'd0, 24'd0, 24'd0);
    chk(wr_clash_o == 1'b0, "R6 clash one cycle", 64'(wr_clash_o), 64'd0);

    // R5: consume the buffer as second operand
    a = {16'h7FFF, 8'd80};
    t0 = t;
    sched(t0 + 12, prod40(a[23:8], w1[23:8], 2), 8'(a[7:0] + w1[7:0] - 8'd64 + 8'd2));
    tick(1, 0, 1, 4'd2, a, 24'hDEAD00);
    chk(!buf_vld_o, "R5 read empties buffer", 64'(buf_vld_o), 64'd0);
    chk(!rd_empty_o, "R5 no empty flag", 64'(rd_empty_o), 64'd0);
    idle_until(t0 + 14);

    // R7: read of an empty buffer
    a = {16'h1234, 8'd100};
    t0 = t;
    sched(t0 + 12, 40'd0, 8'(a[7:0] - 8'd64));
    tick(1, 0, 1, 4'd0, a, 24'h55AA55);
    chk(rd_empty_o == 1'b1, "R7 empty flag", 64'(rd_empty_o), 64'd1);
    tick(0, 0, 0, 4'd0, 24'd0, 24'd0);
    chk(rd_empty_o == 1'b0, "R7 empty one cycle", 64'(rd_empty_o), 64'd0);
    idle_until(t0 + 14);

    // R5: read and write on the same edge
    a = {16'h4000, 8'd64}; b = {16'h4000, 8'd64};
    w2 = resolved(a, b);
    t0 = t;
    tick(1, 1, 0, 4'd3, a, b);
    idle_until(t0 + 14);
    chk(buf_vld_o && buf_word_o == w2, "R4 second fill", {buf_vld_o, buf_word_o}, {1'b1, w2});
    a = {16'h6000, 8'd65}; b = {16'h4000, 8'd63};
    w3 = resolved(a, b);
    t1 = t;
    tick(1, 1, 0, 4'd0, a, b);
    idle_until(t1 + 13);
    a = {16'h4000, 8'd70};
    sched(t + 12, prod40(a[23:8], w2[23:8], 0), 8'(a[7:0] + w2[7:0] - 8'd64));
    tick(1, 0, 1, 4'd0, a, 24'h0F0F0F);
    chk(buf_vld_o && buf_word_o == w3, "R5 same-edge refill", {buf_vld_o, buf_word_o}, {1'b1, w3});
    chk(!wr_clash_o, "R5 same-edge no clash", 64'(wr_clash_o), 64'd0);
    idle_until(t + 16);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule